// File: doc/BRIEF.md
# Nibble-Serial Cell Receiver

This block takes fixed-length cells arriving four bits at a time on a narrow data port. The port runs on its own clock. A frame strobe, sampled together with the first nibble, marks the start of each cell. The block pairs nibbles into bytes, high nibble first. It writes each byte into a cell buffer through a plain address, data and write-strobe interface, one byte per address starting at zero. It raises a one-cycle completion pulse after the final byte of the cell has been written.

A static strap can ask for one filler byte after the header. The header is the first eight bytes, and its last byte is the check byte. With the strap set, the stored cell gains a zero byte at the ninth address, ahead of the payload. The strap is captured only when a cell starts. A frame strobe that arrives while a cell is still being assembled abandons that cell and raises an error pulse. The strobe then starts a new cell at byte zero, so byte alignment is re-established on every cell.

Top module: `cellrx_nibble_port`

## Requirements
- R1: While reset is low and in the first cycle after it, the write strobe, completion pulse and error pulse are all low.
- R2: Each stored byte is {first nibble, second nibble}, with bit 3 of each nibble the most significant bit of that nibble. The write strobe rises in the cycle after the edge that samples the second nibble.
- R3: A cell starts at the rising edge where the frame input is high, and that edge's nibble is the high nibble of byte 0. While no cell is in progress, nibbles sampled with the frame input low produce no write and no pulse.
- R4: Without the filler, the 53 bytes of a cell are written to addresses 0 through 52 in arrival order, one write per byte.
- R5: With the filler, bytes 0..7 go to addresses 0..7 and a 0x00 byte goes to address 8. Bytes 8..52 go to addresses 9..53, for 54 writes. The filler write appears in the cycle after the edge that samples the high nibble of byte 8.
- R6: The filler strap is sampled only at the edge where a cell starts. A change during a cell does not alter that cell's addresses or data.
- R7: The completion pulse is one cycle wide and appears in the cycle directly after the write of the cell's last byte.
- R8: A frame strobe during an unfinished cell gives a one-cycle error pulse in the next cycle. The unfinished cell gets no completion pulse, and the new cell is stored from address 0.
- R9: If the port clock stops, all outputs hold their values, and reception resumes with no lost or repeated nibble.
- R10: A new frame strobe may arrive on the edge right after the last nibble of a cell; both cells are stored and completed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_i | input | 1 | Frame strobe, high with the first nibble of a cell |
| nib_i | input | 4 | Data nibble, bit 3 most significant |
| pad_en_i | input | 1 | Static strap: insert a zero byte after the header |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_addr_o | output | 6 | Buffer byte address |
| wr_data_o | output | 8 | Buffer byte data |
| cell_done_o | output | 1 | One-cycle pulse after the last byte of a cell is written |
| frm_err_o | output | 1 | One-cycle pulse when a cell is cut short by a new frame strobe |

## Verification
The bound checker watches timing and structure on every cycle. Writes inside a cell step up by exactly one address and never pass the end of the largest stored cell. A completion pulse always follows a write and lasts one cycle. Error pulses are single cycles caused by a sampled frame strobe. Only the scoreboard bench can show correct byte contents and nibble order, where the filler lands and its value, the strap being ignored mid-cell, the missing completion pulse on an abandoned cell, back-to-back cells, and state kept while the clock stands still.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    // request from the cell sequencer to the write stage, one edge wide
    typedef struct packed {
        logic restart;   // a frame strobe was sampled: pointer back to 0
        logic err;       // the strobe cut an unfinished cell
        logic byte_wr;   // a full byte is ready this edge
        logic pad_wr;    // the filler byte is due this edge
        logic last;      // byte_wr carries the final byte of the cell
    } cellrx_req_t;

endpackage

// File: rtl/cellrx_nib_pack.sv
module cellrx_nib_pack
    import cellrx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_hi_i,
    input  logic [NIB_W-1:0]  nib_i,
    output logic [BYTE_W-1:0] byte_o
);

    typedef struct packed {
        logic [NIB_W-1:0] hi;
    } pack_st_t;

    pack_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_hi_i) begin
            st_d.hi = nib_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // the byte is only used on the edge that samples its low nibble
    assign byte_o = {st_q.hi, nib_i};

endmodule

// File: rtl/cellrx_seq.sv
module cellrx_seq
    import cellrx_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frm_i,
    input  logic        pad_en_i,
    output logic        take_hi_o,
    output cellrx_req_t req_o
);

    localparam int CW = $clog2(CELL_BYTES);

    typedef struct packed {
        logic          busy;    // a cell is being assembled
        logic          phase;   // 0: next nibble is high, 1: next is low
        logic          pad;     // strap value captured at cell start
        logic [CW-1:0] idx;     // index of the input byte being built
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        req_o     = '0;
        take_hi_o = 1'b0;
        if (frm_i) begin
            // a strobe always opens a fresh cell, aborting any open one
            req_o.restart = 1'b1;
            req_o.err     = st_q.busy;
            take_hi_o     = 1'b1;
            st_d.busy     = 1'b1;
            st_d.phase    = 1'b1;
            st_d.idx      = '0;
            st_d.pad      = pad_en_i;
        end else if (st_q.busy && !st_q.phase) begin
            take_hi_o     = 1'b1;
            st_d.phase    = 1'b1;
            req_o.pad_wr  = st_q.pad && (st_q.idx == CW'(HDR_BYTES));
        end else if (st_q.busy) begin
            req_o.byte_wr = 1'b1;
            st_d.phase    = 1'b0;
            if (st_q.idx == CW'(CELL_BYTES - 1)) begin
                req_o.last = 1'b1;
                st_d.busy  = 1'b0;
                st_d.idx   = '0;
            end else begin
                st_d.idx   = st_q.idx + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cellrx_wr_out.sv
module cellrx_wr_out
    import cellrx_pkg::*;
#(
    parameter int               ADDR_W    = 6,
    parameter logic [BYTE_W-1:0] PAD_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cellrx_req_t       req_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              done_o,
    output logic              err_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic              wr_en;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
        logic              last;
        logic              done;
        logic              err;
    } wr_st_t;

    wr_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.last  = 1'b0;
        st_d.err   = req_i.err;
        st_d.done  = st_q.wr_en && st_q.last;
        if (req_i.restart) begin
            st_d.ptr = '0;
        end else if (req_i.byte_wr) begin
            st_d.wr_en = 1'b1;
            st_d.addr  = st_q.ptr;
            st_d.data  = byte_i;
            st_d.last  = req_i.last;
            st_d.ptr   = st_q.ptr + ADDR_W'(1);
        end else if (req_i.pad_wr) begin
            st_d.wr_en = 1'b1;
            st_d.addr  = st_q.ptr;
            st_d.data  = PAD_VALUE;
            st_d.ptr   = st_q.ptr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o   = st_q.wr_en;
    assign wr_addr_o = st_q.addr;
    assign wr_data_o = st_q.data;
    assign done_o    = st_q.done;
    assign err_o     = st_q.err;

endmodule

// File: rtl/cellrx_nibble_port.sv
module cellrx_nibble_port
    import cellrx_pkg::*;
#(
    parameter int          CELL_BYTES = 53,
    parameter int          HDR_BYTES  = 8,
    parameter logic [7:0]  PAD_VALUE  = 8'h00,
    localparam int         ADDR_W     = $clog2(CELL_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_i,
    input  logic [3:0]        nib_i,
    input  logic              pad_en_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o,
    output logic              cell_done_o,
    output logic              frm_err_o
);

    logic              take_hi;
    cellrx_req_t       req;
    logic [BYTE_W-1:0] asm_byte;

    cellrx_seq #(
        .CELL_BYTES (CELL_BYTES),
        .HDR_BYTES  (HDR_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_i     (frm_i),
        .pad_en_i  (pad_en_i),
        .take_hi_o (take_hi),
        .req_o     (req)
    );

    cellrx_nib_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_hi_i (take_hi),
        .nib_i     (nib_i),
        .byte_o    (asm_byte)
    );

    cellrx_wr_out #(
        .ADDR_W    (ADDR_W),
        .PAD_VALUE (PAD_VALUE)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .byte_i    (asm_byte),
        .wr_en_o   (wr_en_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .done_o    (cell_done_o),
        .err_o     (frm_err_o)
    );

endmodule

// File: rtl/cellrx_nibble_port_chk.sv
module cellrx_nibble_port_chk #(
    parameter int CELL_BYTES = 53,
    parameter int ADDR_W     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_i,
    input logic              wr_en_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic              cell_done_o,
    input logic              frm_err_o
);

    logic [ADDR_W-1:0] prev_addr_q;
    logic [ADDR_W-1:0] step_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_addr_q <= '0;
        end else if (wr_en_o) begin
            prev_addr_q <= wr_addr_o;
        end
    end

    assign step_addr = prev_addr_q + ADDR_W'(1);

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_addr_o != '0) |-> (wr_addr_o == step_addr));

    assert_addr_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (int'(wr_addr_o) <= CELL_BYTES));

    assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cell_done_o |-> $past(wr_en_o));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cell_done_o |=> !cell_done_o);

    assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err_o |=> !frm_err_o);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err_o |-> $past(frm_i));

    assert_err_no_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frm_err_o |-> !cell_done_o);

endmodule

bind cellrx_nibble_port cellrx_nibble_port_chk #(
    .CELL_BYTES (CELL_BYTES),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm_i       (frm_i),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .cell_done_o (cell_done_o),
    .frm_err_o   (frm_err_o)
);

// File: tb/tb_cellrx_nibble_port.sv
module tb_cellrx_nibble_port;

    localparam int CELL = 53;
    localparam int HDR  = 8;

    logic       clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst_n = 1'b0;
    logic       frm_i = 1'b0;
    logic [3:0] nib_i = 4'h0;
    logic       pad_en_i = 1'b0;
    logic       wr_en_o;
    logic [5:0] wr_addr_o;
    logic [7:0] wr_data_o;
    logic       cell_done_o;
    logic       frm_err_o;

    int total = 0;
    int bad = 0;
    int ev_seen = 0;
    bit in_cell = 1'b0;
    bit finished = 1'b0;
    bit prev_wr = 1'b0;

    typedef struct {
        int    kind;   // 0 write, 1 done, 2 error
        int    addr;
        int    data;
        string req;
    } ev_t;

    ev_t exp_q[$];

    cellrx_nibble_port dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_i       (frm_i),
        .nib_i       (nib_i),
        .pad_en_i    (pad_en_i),
        .wr_en_o     (wr_en_o),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o),
        .cell_done_o (cell_done_o),
        .frm_err_o   (frm_err_o)
    );

    initial begin
        forever begin
            #5;
            if (clk_run) clk = ~clk;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input int addr, input int data, input string req);
        ev_t e;
        e.kind = kind; e.addr = addr; e.data = data; e.req = req;
        exp_q.push_back(e);
    endtask

    function automatic logic [7:0] byte_of(input int seed, input int k);
        return 8'((seed * 37 + k * 11 + k * k) ^ (seed << 3));
    endfunction

    task automatic nib(input bit f, input logic [3:0] n);
        @(negedge clk);
        frm_i = f;
        nib_i = n;
    endtask

    // drives nibs nibbles of a cell; pushes what the requirements predict
    task automatic send_cell(input int seed, input bit pad, input int nibs,
                             input bit flip, input bit pause);
        if (in_cell) push(2, 0, 0, "R8");
        for (int j = 0; j < nibs; j++) begin
            int k;
            logic [7:0] b;
            k = j / 2;
            b = byte_of(seed, k);
            if ((j % 2 == 0) && k == HDR && pad) push(0, HDR, 0, "R5");
            if (j % 2 == 1)
                push(0, k + ((pad && k >= HDR) ? 1 : 0), int'(b),
                     pause ? "R9" : (flip ? "R6" : (pad ? "R5" : (k == 0 ? "R2" : "R4"))));
            if (j == 2 * CELL - 1) push(1, 0, 0, "R7");
            if (j == 0) pad_en_i = pad;
            nib(j == 0, (j % 2 == 0) ? b[7:4] : b[3:0]);
            if (flip && j == 5) pad_en_i = !pad;
            if (pause && j == 21) begin
                logic [16:0] snap;
                clk_run = 1'b0;
                snap = {wr_en_o, wr_addr_o, wr_data_o, cell_done_o, frm_err_o};
                #300;
                check(snap == {wr_en_o, wr_addr_o, wr_data_o, cell_done_o, frm_err_o},
                      "R9", "outputs while clock stopped",
                      int'({wr_en_o, wr_addr_o, wr_data_o, cell_done_o, frm_err_o}), int'(snap));
                clk_run = 1'b1;
            end
        end
        in_cell = (nibs < 2 * CELL);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int kind;
            kind = wr_en_o ? 0 : (cell_done_o ? 1 : (frm_err_o ? 2 : -1));
            if (int'(wr_en_o) + int'(cell_done_o) + int'(frm_err_o) > 1)
                check(1'b0, "R7", "more than one event in a cycle", kind, -1);
            if (kind >= 0) begin
                ev_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected event kind", kind, -1);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    check(kind == e.kind, e.req, "event kind", kind, e.kind);
                    if (kind == 0 && e.kind == 0) begin
                        check(int'(wr_addr_o) == e.addr, e.req, "write address",
                              int'(wr_addr_o), e.addr);
                        check(int'(wr_data_o) == e.data, e.req, "write data",
                              int'(wr_data_o), e.data);
                    end
                    if (kind == 1)
                        check(prev_wr, "R7", "done not right after a write", 0, 1);
                end
            end
            prev_wr = wr_en_o;
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seen0;
        repeat (3) @(negedge clk);
        check(!wr_en_o && !cell_done_o && !frm_err_o, "R1", "outputs in reset",
              int'({wr_en_o, cell_done_o, frm_err_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_en_o && !cell_done_o && !frm_err_o, "R1", "outputs after reset",
              int'({wr_en_o, cell_done_o, frm_err_o}), 0);

        // R3: nibbles without a strobe are ignored
        seen0 = ev_seen;
        for (int i = 0; i < 12; i++) nib(1'b0, 4'(i * 5));
        repeat (3) nib(1'b0, 4'h0);
        check(ev_seen == seen0, "R3", "events while idle", ev_seen, seen0);

        send_cell(1, 1'b0, 2 * CELL, 1'b0, 1'b0);  // R2 R4
        send_cell(2, 1'b1, 2 * CELL, 1'b0, 1'b0);  // R10 back-to-back, R5
        send_cell(3, 1'b0, 2 * CELL, 1'b1, 1'b0);  // R6 strap raised mid-cell
        repeat (2) nib(1'b0, 4'h3);
        send_cell(4, 1'b1, 2 * CELL, 1'b1, 1'b0);  // R6 strap dropped mid-cell
        send_cell(5, 1'b0, 31, 1'b0, 1'b0);        // R8 cut mid-byte
        send_cell(6, 1'b1, 17, 1'b0, 1'b0);        // R8 cut after filler
        send_cell(7, 1'b0, 2 * CELL, 1'b0, 1'b0);
        send_cell(8, 1'b1, 2 * CELL, 1'b0, 1'b1);  // R9 clock pause
        repeat (6) nib(1'b0, 4'h0);
        check(exp_q.size() == 0, "R7", "expected events left", exp_q.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule